// File: doc/BRIEF.md
# Receive Sampling Phase Tuner

This block chooses the receive sampling point of a tunable delay line. When started, it first checks whether tuning applies at all: the bus must be in a high-speed tuned mode and the card clock must be above 50 MHz. If either condition is missing, it finishes at once with no error and leaves the delay line alone.

When tuning applies, the block sweeps the tap index upward from 0 to a maximum given on an input. For each tap it writes the tap select and waits for the delay line to acknowledge it. It then requests a tuning-pattern check from an external checker and waits for a pass or fail result. While it sweeps, it tracks runs of consecutive passing taps and keeps the longest one. After the sweep, it programs the centre of that run through the same write and acknowledge handshake and reports the chosen tap. If no tap passes, or an acknowledge does not arrive in time, it finishes with an error.

The controller is a Moore state machine with eight states. IDLE waits for start. SET_TAP issues a tap write. WAIT_ACK waits for the tap acknowledge. RUN_TEST holds the test request until the result arrives. EVAL computes the final tap. SET_FINAL writes the final tap. WAIT_FINAL waits for its acknowledge. FINISH pulses done. The transitions are:
- skip: IDLE to FINISH when tuning does not apply.
- launch: IDLE to SET_TAP.
- issue: SET_TAP to WAIT_ACK.
- acked: WAIT_ACK to RUN_TEST.
- ack_timeout: WAIT_ACK to FINISH.
- advance: RUN_TEST to SET_TAP.
- sweep_end: RUN_TEST to EVAL.
- no_window: EVAL to FINISH.
- centre: EVAL to SET_FINAL.
- final_issue: SET_FINAL to WAIT_FINAL.
- final_ack or final_timeout: WAIT_FINAL to FINISH.
- retire: FINISH to IDLE.

Top module: `phase_tune_ctrl`

## Requirements
- R1: After reset, done, error, tap_wr, test_req and busy are 0, and chosen_tap is 0.
- R2: A start while tuned_mode or clk_fast is 0 yields a done pulse with error 0, issues no tap write and leaves chosen_tap unchanged.
- R3: During the sweep, one tap write is issued for each tap from 0 to max_tap inclusive, in ascending order, with tap_sel carrying the tap while tap_wr is 1.
- R4: The test request is raised only after the acknowledge for the current tap. If the acknowledge is missing for TIMEOUT_CYC consecutive wait cycles, the run ends with error 1 and no test for that tap. An acknowledge in the last of those cycles is still accepted.
- R5: A passing result extends the current run of passing taps and a failing result clears it. The best run is replaced only by a strictly longer run, so the earliest of equal-length runs is kept.
- R6: After the sweep, the tap written is the end tap of the best run minus the floor of half its length. chosen_tap takes that value when its acknowledge arrives, and done follows with error 0.
- R7: If no tap passes, the run ends with error 1, no final tap is written and chosen_tap is unchanged.
- R8: If the final tap is not acknowledged within TIMEOUT_CYC wait cycles, the run ends with error 1 and chosen_tap is unchanged.
- R9: done is a single-cycle pulse, error is 1 only while done is 1, and tap_wr, test_req and done are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a tuning run (accepted in IDLE) |
| tuned_mode | input | 1 | Bus is in a high-speed tuned mode |
| clk_fast | input | 1 | Card clock is above 50 MHz |
| max_tap | input | TAP_W | Highest tap index to sweep |
| tap_sel | output | TAP_W | Tap select presented to the delay line |
| tap_wr | output | 1 | One-cycle strobe writing tap_sel |
| tap_ack | input | 1 | Delay line acknowledges the latest tap write |
| test_req | output | 1 | Request a tuning-pattern check, held until answered |
| test_resp_valid | input | 1 | Check result is valid |
| test_pass | input | 1 | Check result, 1 for pass |
| busy | output | 1 | Controller is not idle |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed, valid with done |
| chosen_tap | output | TAP_W | Last successfully programmed tap |

## Verification
The assertions assume an environment that behaves like a real delay line and checker. max_tap must stay stable while busy is 1. tap_ack must come only while a tap write is outstanding. test_resp_valid must come only while test_req is 1. The bench responder meets these assumptions by construction. It sets max_tap before each start and drives the acknowledge a programmable number of cycles after it sees a tap write. It answers only a pending request, from a pass mask indexed by the tap under test. It can also withhold the acknowledge for one chosen write, which produces the timeout cases, including the acknowledge delays just inside and just outside the limit.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SET_TAP    = 3'd1,
        ST_WAIT_ACK   = 3'd2,
        ST_RUN_TEST   = 3'd3,
        ST_EVAL       = 3'd4,
        ST_SET_FINAL  = 3'd5,
        ST_WAIT_FINAL = 3'd6,
        ST_FINISH     = 3'd7
    } tune_state_t;

endpackage

// File: rtl/ptc_wait_timer.sv
module ptc_wait_timer #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/ptc_run_track.sv
module ptc_run_track #(
    parameter int TAP_W = 6,
    parameter int LEN_W = TAP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             update,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic [LEN_W-1:0] best_len,
    output logic [TAP_W-1:0] best_end
);
    logic [LEN_W-1:0] cur_q;
    logic [LEN_W-1:0] best_q;
    logic [TAP_W-1:0] end_q;
    logic [LEN_W-1:0] cur_inc;

    assign cur_inc = cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clear) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (update) begin
            if (pass) begin
                cur_q <= cur_inc;
                if (cur_inc > best_q) begin
                    best_q <= cur_inc;
                    end_q  <= tap;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    assign best_len = best_q;
    assign best_end = end_q;
endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
    import phase_tune_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tuned_mode,
    input  logic             clk_fast,
    input  logic [TAP_W-1:0] max_tap,
    output logic [TAP_W-1:0] tap_sel,
    output logic             tap_wr,
    input  logic             tap_ack,
    output logic             test_req,
    input  logic             test_resp_valid,
    input  logic             test_pass,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [TAP_W-1:0] chosen_tap
);
    localparam int LEN_W = TAP_W + 1;

    tune_state_t      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             err_q;
    logic [TAP_W-1:0] chosen_q;
    logic             waiting;
    logic             expired;
    logic             trk_clear;
    logic             trk_update;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] best_end;
    logic [TAP_W-1:0] centre_tap;
    logic             last_tap;

    assign waiting    = (state_q == ST_WAIT_ACK) || (state_q == ST_WAIT_FINAL);
    assign trk_clear  = (state_q == ST_IDLE) && start;
    assign trk_update = (state_q == ST_RUN_TEST) && test_resp_valid;
    assign last_tap   = (tap_q == max_tap);
    assign centre_tap = TAP_W'(({1'b0, best_end}) - (best_len >> 1));

    ptc_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    ptc_run_track #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (trk_clear),
        .update   (trk_update),
        .pass     (test_pass),
        .tap      (tap_q),
        .best_len (best_len),
        .best_end (best_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (tuned_mode && clk_fast) ? ST_SET_TAP : ST_FINISH;
                end
            end
            ST_SET_TAP:  state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (tap_ack)      state_d = ST_RUN_TEST;
                else if (expired) state_d = ST_FINISH;
            end
            ST_RUN_TEST: begin
                if (test_resp_valid) state_d = last_tap ? ST_EVAL : ST_SET_TAP;
            end
            ST_EVAL:       state_d = (best_len == '0) ? ST_FINISH : ST_SET_FINAL;
            ST_SET_FINAL:  state_d = ST_WAIT_FINAL;
            ST_WAIT_FINAL: begin
                if (tap_ack || expired) state_d = ST_FINISH;
            end
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tap_q    <= '0;
            err_q    <= 1'b0;
            chosen_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tap_q <= '0;
                        err_q <= 1'b0;
                    end
                end
                ST_WAIT_ACK: begin
                    if (!tap_ack && expired) err_q <= 1'b1;
                end
                ST_RUN_TEST: begin
                    if (test_resp_valid && !last_tap) tap_q <= tap_q + 1'b1;
                end
                ST_EVAL: begin
                    if (best_len == '0) err_q <= 1'b1;
                    else                tap_q <= centre_tap;
                end
                ST_WAIT_FINAL: begin
                    if (tap_ack)      chosen_q <= tap_q;
                    else if (expired) err_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tap_sel    = tap_q;
        tap_wr     = (state_q == ST_SET_TAP) || (state_q == ST_SET_FINAL);
        test_req   = (state_q == ST_RUN_TEST);
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        error      = (state_q == ST_FINISH) && err_q;
        chosen_tap = chosen_q;
    end
endmodule

// File: rtl/phase_tune_ctrl_chk.sv
module phase_tune_ctrl_chk #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] max_tap,
    input logic [TAP_W-1:0] tap_sel,
    input logic             tap_wr,
    input logic             tap_ack,
    input logic             test_req,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [TAP_W-1:0] chosen_tap
);
    // R9: exclusive strobes
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tap_wr, test_req, done}));

    // R9: error only alongside done
    assert_error_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: test only after acknowledge
    assert_test_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req) |-> $past(tap_ack));

    // R3: written taps stay in range
    assert_tap_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tap_wr |-> (tap_sel <= max_tap));

    // R6: chosen tap changes only on a successful finish
    assert_chosen_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chosen_tap != $past(chosen_tap)) |-> (done && !error));

    // R1: idle means no activity
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tap_wr && !test_req && !done));
endmodule

bind phase_tune_ctrl phase_tune_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .max_tap    (max_tap),
    .tap_sel    (tap_sel),
    .tap_wr     (tap_wr),
    .tap_ack    (tap_ack),
    .test_req   (test_req),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .chosen_tap (chosen_tap)
);

// File: tb/phase_tune_ctrl_tb.sv
`timescale 1ns/1ps
module phase_tune_ctrl_tb_top;
    localparam int TAP_W = 6;
    localparam int TMO   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             tuned_mode = 1'b1;
    logic             clk_fast = 1'b1;
    logic [TAP_W-1:0] max_tap = '0;
    logic [TAP_W-1:0] tap_sel;
    logic             tap_wr;
    logic             tap_ack = 1'b0;
    logic             test_req;
    logic             test_resp_valid = 1'b0;
    logic             test_pass = 1'b0;
    logic             busy, done, error;
    logic [TAP_W-1:0] chosen_tap;

    always #2.5 clk = ~clk;

    phase_tune_ctrl #(.TAP_W(TAP_W), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tuned_mode(tuned_mode),
        .clk_fast(clk_fast), .max_tap(max_tap), .tap_sel(tap_sel),
        .tap_wr(tap_wr), .tap_ack(tap_ack), .test_req(test_req),
        .test_resp_valid(test_resp_valid), .test_pass(test_pass),
        .busy(busy), .done(done), .error(error), .chosen_tap(chosen_tap)
    );

    int n_checks = 0;
    int n_fail = 0;

    // responder configuration and log
    logic [63:0] pass_mask = '0;
    int ack_delay = 0;
    int block_idx = -1;
    int wr_count = 0;
    int test_count = 0;
    int wr_log [0:127];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // delay line and checker model
    initial begin
        bit ack_pend = 0;
        int ack_wait = 0;
        bit ack_block = 0;
        forever begin
            @(negedge clk);
            tap_ack = 1'b0;
            test_resp_valid = 1'b0;
            if (tap_wr) begin
                if (wr_count < 128) wr_log[wr_count] = int'(tap_sel);
                ack_block = (wr_count == block_idx);
                wr_count++;
                ack_pend = 1;
                ack_wait = ack_delay;
            end else if (ack_pend) begin
                if (ack_wait == 0) begin
                    tap_ack = !ack_block;
                    ack_pend = 0;
                end else begin
                    ack_wait--;
                end
            end
            if (test_req) begin
                test_resp_valid = 1'b1;
                test_pass = pass_mask[tap_sel];
                test_count++;
            end
        end
    end

    function automatic int model_final(input logic [63:0] m, input int mx, output int blen);
        int cur = 0;
        int best = 0;
        int endi = 0;
        for (int i = 0; i <= mx; i++) begin
            if (m[i]) begin
                cur++;
                if (cur > best) begin
                    best = cur;
                    endi = i;
                end
            end else begin
                cur = 0;
            end
        end
        blen = best;
        return endi - best / 2;
    endfunction

    task automatic run_tune(input int mx, output bit err, output bit seen);
        max_tap = TAP_W'(mx);
        wr_count = 0;
        test_count = 0;
        seen = 0;
        err = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 6000 && !seen; c++) begin
            if (done) begin
                seen = 1;
                err = error;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        chk(!done, "R9 done single cycle", int'(done), 0);
    endtask

    task automatic sweep_case(input string name, input logic [63:0] m, input int mx, input int dly);
        bit err, seen;
        int blen, fin;
        int prev = int'(chosen_tap);
        bit order_ok = 1;
        pass_mask = m;
        ack_delay = dly;
        block_idx = -1;
        fin = model_final(m, mx, blen);
        run_tune(mx, err, seen);
        chk(seen, {name, " R6 done seen"}, int'(seen), 1);
        for (int i = 0; i <= mx; i++) if (wr_log[i] != i) order_ok = 0;
        chk(order_ok, {name, " R3 sweep order"}, int'(order_ok), 1);
        chk(test_count == mx + 1, {name, " R4 one test per tap"}, test_count, mx + 1);
        if (blen == 0) begin
            chk(err, {name, " R7 error on empty window"}, int'(err), 1);
            chk(wr_count == mx + 1, {name, " R7 no final write"}, wr_count, mx + 1);
            chk(int'(chosen_tap) == prev, {name, " R7 chosen kept"}, int'(chosen_tap), prev);
        end else begin
            chk(!err, {name, " R6 no error"}, int'(err), 0);
            chk(wr_count == mx + 2, {name, " R3 write count"}, wr_count, mx + 2);
            chk(wr_log[mx + 1] == fin, {name, " R5 final tap written"}, wr_log[mx + 1], fin);
            chk(int'(chosen_tap) == fin, {name, " R6 chosen tap"}, int'(chosen_tap), fin);
        end
    endtask

    task automatic t_reset;
        chk(!done && !error && !tap_wr && !test_req && !busy, "R1 outputs idle", int'({done, error, tap_wr, test_req, busy}), 0);
        chk(chosen_tap == '0, "R1 chosen zero", int'(chosen_tap), 0);
    endtask

    task automatic t_skip(input bit tm, input bit cf);
        bit err, seen;
        int prev = int'(chosen_tap);
        tuned_mode = tm;
        clk_fast = cf;
        run_tune(31, err, seen);
        chk(seen && !err, "R2 skip finishes cleanly", int'({seen, err}), 2);
        chk(wr_count == 0, "R2 skip no tap write", wr_count, 0);
        chk(int'(chosen_tap) == prev, "R2 skip chosen kept", int'(chosen_tap), prev);
        tuned_mode = 1'b1;
        clk_fast = 1'b1;
    endtask

    task automatic t_timeout_sweep(input int dly, input bit expect_err);
        bit err, seen;
        pass_mask = 64'hFF;
        ack_delay = dly;
        block_idx = -1;
        run_tune(3, err, seen);
        chk(seen && err == expect_err, "R4 ack delay boundary", int'(err), int'(expect_err));
        if (expect_err) chk(test_count == 0, "R4 no test without ack", test_count, 0);
        ack_delay = 0;
    endtask

    task automatic t_timeout_block;
        bit err, seen;
        pass_mask = 64'hFF;
        ack_delay = 0;
        block_idx = 2;
        run_tune(7, err, seen);
        chk(err, "R4 missing ack mid-sweep", int'(err), 1);
        chk(test_count == 2 && wr_count == 3, "R4 sweep stops at blocked tap", test_count, 2);
        block_idx = -1;
    endtask

    task automatic t_timeout_final;
        bit err, seen;
        int prev = int'(chosen_tap);
        pass_mask = 64'h0F00;
        ack_delay = 0;
        block_idx = 16;
        run_tune(15, err, seen);
        chk(err, "R8 final ack timeout error", int'(err), 1);
        chk(wr_count == 17, "R8 final write issued", wr_count, 17);
        chk(int'(chosen_tap) == prev, "R8 chosen kept", int'(chosen_tap), prev);
        block_idx = -1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_skip(1'b0, 1'b1);
        t_skip(1'b1, 1'b0);
        sweep_case("single window", 64'h0003_FC00, 31, 0);
        sweep_case("tie keeps first R5", 64'h00F0_003C, 31, 1);
        sweep_case("window at top", 64'hF000_0000, 31, 2);
        sweep_case("odd length", 64'h0000_03E0, 31, 0);
        sweep_case("short sweep all pass", 64'hFFFF_FFFF, 7, 0);
        sweep_case("longer later run R5", 64'h0007_FC06, 31, 0);
        sweep_case("single tap", 64'h1, 0, 0);
        sweep_case("no pass", 64'h0, 31, 0);
        t_timeout_sweep(TMO - 1, 1'b0);
        t_timeout_sweep(TMO, 1'b1);
        t_timeout_block();
        sweep_case("restore", 64'h0000_0FF0, 15, 0);
        t_timeout_final();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule